// File: doc/BRIEF.md
# Three-Channel Integrating Conversion Sequencer

This block runs timed conversions for the green, red and blue light channels, one after another. The analog integrator of each channel is modelled as a pulse input. While a channel is selected, the block counts that channel's pulses over an integration window measured in oscillator ticks. At the end of each window the count is copied into a result register for that channel. The next enabled channel then starts at once. The block keeps converting until the configuration tells it to stop.

A 3-bit mode selects which channels take part. A resolution bit selects a long window with a 16-bit result or a short window with a 12-bit result. A sync bit chooses how a run is started: either by the write strobe of the configuration register, or by a rising edge on the external trigger pin. Status outputs show which channel is being integrated and whether a result has been produced since the last start. A one-cycle done pulse goes to the interrupt logic. The trigger pin is assumed to be already synchronous to `clk`.

Top module: `rgb_conv_seq`

## Requirements
- R1: While reset is asserted and after its release, all three results read 0, and `conv_flag`, `chan_busy` and `done_pulse` read 0.
- R2: `mode` selects the channels as follows: 001 green, 010 red, 011 blue, 101 green+red+blue, 110 green+red, 111 green+blue. Channels are converted in the order green, red, blue, and channels not selected are skipped. `chan_busy` reads 01 for green, 10 for red and 11 for blue.
- R3: With `mode` at 000 (power-down) or 100 (standby), no conversion runs: `chan_busy` reads 00 and the results keep their values.
- R4: A window lasts 65536 `osc_tick` cycles when `res_12b`=0 and 4096 when `res_12b`=1. `done_pulse` is high for exactly one cycle, in the cycle after the clock edge that ends the window.
- R5: A result holds the number of cycles in its window in which the active channel's pulse input was high. A result register changes only at the end of a window of its own channel, together with `done_pulse`.
- R6: The count saturates at 0xFFFF in 16-bit mode and at 0x0FFF in 12-bit mode. A 12-bit result has bits 15:12 at zero.
- R7: With `sync_en`=0, a `cfg_wr` strobe with an active mode starts a run from the first selected channel. The trigger pin has no effect.
- R8: With `sync_en`=1, a `cfg_wr` strobe stops any run and leaves the block idle. Each rising edge of `ext_trig` with an active mode starts or restarts the run from the first selected channel. A trigger held high does not start it again.
- R9: A `cfg_wr` strobe in the middle of a window abandons that window without changing any result, and restarts the sequence as R7 or R8 says.
- R10: `conv_flag` is cleared by every start and set at the end of every window.
- R11: After the last selected channel, conversion wraps back to the first selected channel and continues without a gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | Integration oscillator tick enable |
| pulse_in | input | 3 | Integrator pulses, bit 0 green, bit 1 red, bit 2 blue |
| mode | input | 3 | Channel-set selection |
| res_12b | input | 1 | 1 selects the 12-bit short window |
| sync_en | input | 1 | 1 selects start by rising trigger edge |
| cfg_wr | input | 1 | One-cycle strobe for a configuration write |
| ext_trig | input | 1 | External start trigger |
| data_g | output | 16 | Green result |
| data_r | output | 16 | Red result |
| data_b | output | 16 | Blue result |
| conv_flag | output | 1 | A result has been produced since the last start |
| chan_busy | output | 2 | Channel currently being integrated |
| done_pulse | output | 1 | One-cycle end-of-conversion pulse |

## Verification
The bench goes after four corner cases. The first is a configuration write in the middle of a window: a design that latched the partial count there would show a result that is too small at the wrong time. The second is a trigger held high, or toggling while `sync_en` is low: a design that restarted on the level, or on ignored edges, would never finish a window, so its flag would stay low. The third is saturation at both resolutions: an unclamped counter would wrap to a small value, or would leak bits above bit 11 in 12-bit mode. The fourth is a two-channel mode that skips red: a design with a wrong skip rule would visit red or lose its position at the wrap.

// File: rtl/rgb_seq_pkg.sv
package rgb_seq_pkg;

  typedef enum logic [1:0] {
    CH_NONE = 2'd0,
    CH_G    = 2'd1,
    CH_R    = 2'd2,
    CH_B    = 2'd3
  } chan_e;

  // Enabled channel set: bit 0 green, bit 1 red, bit 2 blue.
  function automatic logic [2:0] chan_mask(input logic [2:0] mode);
    case (mode)
      3'b001:  return 3'b001;
      3'b010:  return 3'b010;
      3'b011:  return 3'b100;
      3'b101:  return 3'b111;
      3'b110:  return 3'b011;
      3'b111:  return 3'b101;
      default: return 3'b000;
    endcase
  endfunction

  function automatic chan_e first_chan(input logic [2:0] mode);
    logic [2:0] m;
    m = chan_mask(mode);
    if (m[0]) return CH_G;
    if (m[1]) return CH_R;
    if (m[2]) return CH_B;
    return CH_NONE;
  endfunction

  function automatic chan_e next_chan(input logic [2:0] mode, input chan_e cur);
    logic [2:0] m;
    m = chan_mask(mode);
    case (cur)
      CH_G: begin
        if (m[1]) return CH_R;
        if (m[2]) return CH_B;
      end
      CH_R: begin
        if (m[2]) return CH_B;
      end
      default: ;
    endcase
    return first_chan(mode);
  endfunction

endpackage

// File: rtl/rgb_seq_ctrl.sv
module rgb_seq_ctrl
  import rgb_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode,
  input  logic       sync_en,
  input  logic       cfg_wr,
  input  logic       ext_trig,
  input  logic       last_tick,
  output chan_e      chan,
  output logic       start,
  output logic       commit,
  output logic       clr
);

  logic  ext_q;
  logic  run_q, run_d;
  chan_e chan_q, chan_d;
  logic  active, rise;

  always_comb begin
    active = (chan_mask(mode) != 3'b000);
    rise   = ext_trig & ~ext_q;
    start  = active & ((cfg_wr & ~sync_en) | (~cfg_wr & sync_en & rise));
    commit = active & ~cfg_wr & ~(sync_en & rise) & run_q & last_tick;
    run_d  = run_q;
    chan_d = chan_q;
    if (!active) begin
      run_d  = 1'b0;
      chan_d = CH_NONE;
    end else if (start) begin
      run_d  = 1'b1;
      chan_d = first_chan(mode);
    end else if (cfg_wr) begin
      run_d  = 1'b0;
      chan_d = CH_NONE;
    end else if (commit) begin
      chan_d = next_chan(mode, chan_q);
    end
    clr = start | commit | ~run_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_q  <= 1'b0;
      run_q  <= 1'b0;
      chan_q <= CH_NONE;
    end else begin
      ext_q  <= ext_trig;
      run_q  <= run_d;
      chan_q <= chan_d;
    end
  end

  assign chan = chan_q;

endmodule

// File: rtl/rgb_win_counter.sv
module rgb_win_counter #(
  parameter int DATA_W  = 16,
  parameter int SHORT_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              osc_tick,
  input  logic              pulse,
  input  logic              res_12b,
  output logic              last_tick,
  output logic [DATA_W-1:0] sum_sat
);

  localparam logic [DATA_W-1:0] FULL_MAX  = {DATA_W{1'b1}};
  localparam logic [DATA_W-1:0] SHORT_MAX = {{(DATA_W-SHORT_W){1'b0}}, {SHORT_W{1'b1}}};

  logic [DATA_W-1:0] tcnt_q, tcnt_d;
  logic [DATA_W-1:0] acc_q, acc_d;
  logic [DATA_W-1:0] lim;
  logic [DATA_W:0]   sum_w;

  always_comb begin
    lim       = res_12b ? SHORT_MAX : FULL_MAX;
    sum_w     = {1'b0, acc_q} + {{DATA_W{1'b0}}, pulse};
    sum_sat   = (sum_w > {1'b0, lim}) ? lim : sum_w[DATA_W-1:0];
    last_tick = osc_tick & (tcnt_q == lim);
    if (clr) begin
      tcnt_d = '0;
      acc_d  = '0;
    end else begin
      acc_d  = sum_sat;
      tcnt_d = osc_tick ? tcnt_q + 1'b1 : tcnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt_q <= '0;
      acc_q  <= '0;
    end else begin
      tcnt_q <= tcnt_d;
      acc_q  <= acc_d;
    end
  end

endmodule

// File: rtl/rgb_result_bank.sv
module rgb_result_bank #(
  parameter int DATA_W = 16,
  parameter int NCH    = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic                      commit,
  input  logic [1:0]                chan,
  input  logic [DATA_W-1:0]         sum_sat,
  output logic [NCH-1:0][DATA_W-1:0] bank,
  output logic                      flag,
  output logic                      done
);

  logic flag_d;

  for (genvar i = 0; i < NCH; i++) begin : g_slot
    logic              wr_en;
    logic [DATA_W-1:0] slot_q;
    assign wr_en = commit & (chan == 2'(i + 1));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     slot_q <= '0;
      else if (wr_en) slot_q <= sum_sat;
    end
    assign bank[i] = slot_q;
  end

  always_comb begin
    flag_d = flag;
    if (start)       flag_d = 1'b0;
    else if (commit) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
      done <= 1'b0;
    end else begin
      flag <= flag_d;
      done <= commit;
    end
  end

endmodule

// File: rtl/rgb_conv_seq.sv
module rgb_conv_seq
  import rgb_seq_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int SHORT_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_tick,
  input  logic [2:0]        pulse_in,
  input  logic [2:0]        mode,
  input  logic              res_12b,
  input  logic              sync_en,
  input  logic              cfg_wr,
  input  logic              ext_trig,
  output logic [DATA_W-1:0] data_g,
  output logic [DATA_W-1:0] data_r,
  output logic [DATA_W-1:0] data_b,
  output logic              conv_flag,
  output logic [1:0]        chan_busy,
  output logic              done_pulse
);

  localparam int NCH = 3;

  chan_e                     chan;
  logic                      start, commit, clr, last_tick, pulse_sel;
  logic [DATA_W-1:0]         sum_sat;
  logic [NCH-1:0][DATA_W-1:0] bank;

  always_comb begin
    case (chan)
      CH_G:    pulse_sel = pulse_in[0];
      CH_R:    pulse_sel = pulse_in[1];
      CH_B:    pulse_sel = pulse_in[2];
      default: pulse_sel = 1'b0;
    endcase
  end

  rgb_seq_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .sync_en   (sync_en),
    .cfg_wr    (cfg_wr),
    .ext_trig  (ext_trig),
    .last_tick (last_tick),
    .chan      (chan),
    .start     (start),
    .commit    (commit),
    .clr       (clr)
  );

  rgb_win_counter #(.DATA_W(DATA_W), .SHORT_W(SHORT_W)) u_win (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .osc_tick  (osc_tick),
    .pulse     (pulse_sel),
    .res_12b   (res_12b),
    .last_tick (last_tick),
    .sum_sat   (sum_sat)
  );

  rgb_result_bank #(.DATA_W(DATA_W), .NCH(NCH)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .commit  (commit),
    .chan    (chan),
    .sum_sat (sum_sat),
    .bank    (bank),
    .flag    (conv_flag),
    .done    (done_pulse)
  );

  assign data_g    = bank[0];
  assign data_r    = bank[1];
  assign data_b    = bank[2];
  assign chan_busy = chan;

endmodule

// File: rtl/rgb_conv_seq_chk.sv
module rgb_conv_seq_chk #(
  parameter int DATA_W  = 16,
  parameter int SHORT_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        mode,
  input logic              res_12b,
  input logic [DATA_W-1:0] data_g,
  input logic [DATA_W-1:0] data_r,
  input logic [DATA_W-1:0] data_b,
  input logic              conv_flag,
  input logic [1:0]        chan_busy,
  input logic              done_pulse
);

  AST_IDLE_NO_CHAN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode == 3'b000 || mode == 3'b100) |-> chan_busy == 2'b00); // R3

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !done_pulse); // R4

  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_pulse |-> $stable({data_g, data_r, data_b})); // R5

  AST_SHORT_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    (done_pulse && $past(res_12b) && $past(chan_busy) == 2'b01)
      |-> data_g[DATA_W-1:SHORT_W] == '0); // R6

  AST_FLAG_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> conv_flag); // R10

endmodule

bind rgb_conv_seq rgb_conv_seq_chk #(.DATA_W(DATA_W), .SHORT_W(SHORT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode       (mode),
  .res_12b    (res_12b),
  .data_g     (data_g),
  .data_r     (data_r),
  .data_b     (data_b),
  .conv_flag  (conv_flag),
  .chan_busy  (chan_busy),
  .done_pulse (done_pulse)
);

// File: tb/rgb_conv_seq_bench.sv
`timescale 1ns/1ps
module rgb_conv_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        osc_tick = 1'b1;
  logic [2:0]  pulse_in = 3'b000;
  logic [2:0]  mode = 3'b000;
  logic        res_12b = 1'b1;
  logic        sync_en = 1'b0;
  logic        cfg_wr = 1'b0;
  logic        ext_trig = 1'b0;
  logic [15:0] data_g, data_r, data_b;
  logic        conv_flag, done_pulse;
  logic [1:0]  chan_busy;

  int nchk = 0, nerr = 0, cyc = 0, last_done = 0, gap = 0;
  int dens[3] = '{30, 60, 90};
  bit osc_all = 1, ext_rand = 0, finished = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  rgb_conv_seq u_rgb_conv_seq (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .pulse_in(pulse_in),
    .mode(mode), .res_12b(res_12b), .sync_en(sync_en), .cfg_wr(cfg_wr),
    .ext_trig(ext_trig), .data_g(data_g), .data_r(data_r), .data_b(data_b),
    .conv_flag(conv_flag), .chan_busy(chan_busy), .done_pulse(done_pulse)
  );

  // Expected behaviour from the requirements
  function automatic logic [2:0] b_set(input logic [2:0] m);
    case (m)
      3'b001: return 3'b001; 3'b010: return 3'b010; 3'b011: return 3'b100;
      3'b101: return 3'b111; 3'b110: return 3'b011; 3'b111: return 3'b101;
      default: return 3'b000;
    endcase
  endfunction

  function automatic int b_next(input logic [2:0] m, input int cur);
    logic [2:0] s;
    s = b_set(m);
    for (int i = cur; i < 3; i++) if (s[i]) return i + 1;
    for (int i = 0; i < 3; i++) if (s[i]) return i + 1;
    return 0;
  endfunction

  int          m_run, m_ch;
  int unsigned m_t, m_acc, lim, wlen, sum;
  logic [15:0] m_res[3];
  bit          m_flag, m_done, m_extq, rise, act;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_ch = 0; m_t = 0; m_acc = 0;
      m_res[0] = 0; m_res[1] = 0; m_res[2] = 0;
      m_flag = 0; m_done = 0; m_extq = 0;
    end else begin
      act = (b_set(mode) != 3'b000);
      rise = ext_trig && !m_extq;
      m_extq = ext_trig;
      m_done = 0;
      lim  = res_12b ? 4095 : 65535;
      wlen = res_12b ? 4096 : 65536;
      if (!act) begin
        m_run = 0; m_ch = 0;
      end else if (cfg_wr) begin
        if (!sync_en) begin m_run = 1; m_ch = b_next(mode, 0); m_t = 0; m_acc = 0; m_flag = 0; end
        else begin m_run = 0; m_ch = 0; end
      end else if (sync_en && rise) begin
        m_run = 1; m_ch = b_next(mode, 0); m_t = 0; m_acc = 0; m_flag = 0;
      end else if (m_run != 0) begin
        sum = m_acc + pulse_in[m_ch-1];
        if (sum > lim) sum = lim;
        if (osc_tick && m_t == wlen - 1) begin
          m_res[m_ch-1] = sum[15:0]; m_done = 1; m_flag = 1;
          m_ch = b_next(mode, m_ch); m_t = 0; m_acc = 0;
        end else begin
          m_acc = sum;
          if (osc_tick) m_t++;
        end
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act_v, input logic [31:0] exp_v);
    nchk++;
    if (act_v !== exp_v) begin
      nerr++;
      $display("FAIL %s actual %h expected %h", req, act_v, exp_v);
    end
  endtask

  task automatic compare();
    chk({"R5 data_g [", tag, "]"}, data_g, m_res[0]);
    chk({"R5 data_r [", tag, "]"}, data_r, m_res[1]);
    chk({"R5 data_b [", tag, "]"}, data_b, m_res[2]);
    chk({"R2 chan_busy [", tag, "]"}, chan_busy, m_ch);
    chk({"R10 conv_flag [", tag, "]"}, conv_flag, m_flag);
    chk({"R4 done_pulse [", tag, "]"}, done_pulse, m_done);
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      compare();
      cyc++;
      if (done_pulse) begin gap = cyc - last_done; last_done = cyc; end
      cfg_wr = 1'b0;
      for (int c = 0; c < 3; c++) pulse_in[c] = (($urandom % 100) < dens[c]);
      osc_tick = osc_all ? 1'b1 : 1'($urandom % 2);
      if (ext_rand) ext_trig = 1'($urandom % 2);
    end
  endtask

  task automatic write_cfg(input logic [2:0] m, input logic r, input logic s);
    mode = m; res_12b = r; sync_en = s; cfg_wr = 1'b1;
    step(1);
  endtask

  logic [15:0] keep_r, keep_g, keep_b;

  initial begin
    void'($urandom(32'h1a2b3c));
    repeat (3) @(negedge clk);
    chk("R1 reset data_g", data_g, 0);
    chk("R1 reset flag/chan/done", {conv_flag, chan_busy, done_pulse}, 0);
    rst_n = 1'b1;
    step(2);
    chk("R1 after release", {data_r, data_b, conv_flag, chan_busy, done_pulse}, 0);

    tag = "R11";
    write_cfg(3'b101, 1'b1, 1'b0);
    step(4 * 4096 + 20);
    chk("R4 12-bit window gap", gap, 4096);
    chk("R11 wrap reached red", chan_busy, 2);

    tag = "R2";
    dens = '{45, 100, 15};
    write_cfg(3'b111, 1'b1, 1'b0);
    step(2 * 4096 + 100);
    chk("R2 green-blue wraps to green", chan_busy, 1);

    tag = "R9";
    write_cfg(3'b010, 1'b1, 1'b0);
    step(2000);
    keep_r = data_r;
    write_cfg(3'b010, 1'b1, 1'b0);
    step(3000);
    chk("R9 abandoned window left result", data_r, keep_r);
    step(1200);

    tag = "R8";
    ext_trig = 1'b0;
    write_cfg(3'b011, 1'b1, 1'b1);
    step(300);
    chk("R8 idle until edge", chan_busy, 0);
    ext_trig = 1'b1;
    step(1);
    chk("R8 edge starts blue", chan_busy, 3);
    step(5000);
    chk("R8 held level no restart", conv_flag, 1);
    ext_trig = 1'b0;
    step(1000);
    ext_trig = 1'b1;
    step(1);
    chk("R10 restart clears flag", conv_flag, 0);

    tag = "R7";
    ext_rand = 1;
    write_cfg(3'b001, 1'b1, 1'b0);
    step(5000);
    ext_rand = 0;
    chk("R7 trigger ignored, window finished", conv_flag, 1);

    tag = "R4";
    osc_all = 0;
    write_cfg(3'b001, 1'b1, 1'b0);
    step(9500);
    osc_all = 1;

    tag = "R6";
    dens = '{100, 100, 100};
    write_cfg(3'b001, 1'b1, 1'b0);
    step(4096 + 5);
    chk("R6 12-bit saturation", data_g, 16'h0FFF);
    write_cfg(3'b010, 1'b0, 1'b0);
    step(65536 + 5);
    chk("R6 16-bit saturation", data_r, 16'hFFFF);

    tag = "R3";
    dens = '{50, 50, 50};
    keep_g = data_g; keep_r = data_r; keep_b = data_b;
    write_cfg(3'b000, 1'b1, 1'b0);
    step(3000);
    chk("R3 power-down chan", chan_busy, 0);
    chk("R3 power-down data", {data_g, data_r, data_b}, {keep_g, keep_r, keep_b});
    write_cfg(3'b100, 1'b1, 1'b0);
    step(3000);
    chk("R3 standby chan", chan_busy, 0);
    chk("R3 standby data_b", data_b, keep_b);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nchk++; nerr++;
      $display("FAIL watchdog [%s] actual hung expected finish", tag);
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

endmodule